// File: doc/BRIEF.md
# Read-While-Write Bank Arbiter

This block sits beside the command logic of a multi-bank NOR flash model. It keeps a mode for each of nine banks and decides, for every read, whether the array may be read or whether a busy/status code is returned instead. It takes operation starts from the command decoder: program, single block erase, multi-block erase, suspend, resume, software reset and hardware reset. It also takes completion pulses, normal or abnormal, from the program/erase timing model. A program or erase may run in one bank while reads are served from every other bank that can deliver array data.

Banks are picked by a 6-bit bank-address field. Each code stands for a 0.5 Mbit unit, so the small bank owns one code, the 3.5 Mbit bank owns seven codes and each 4 Mbit bank owns eight. An erase may be suspended, and a program started inside the suspended erase bank may itself be suspended. A multi-block erase that covers all nine banks blocks every read until it ends. An abnormal end leaves the bank locked until a software reset clears it.

Top module: `rww_bank_arbiter`

## Requirements
- R1: Bank-address code 0 selects bank 0, codes 1 to 7 select bank 1, and codes 8k to 8k+7 (k = 1..7) select bank k+1.
- R2: After the reset input is released, every bank is in read mode (mode 0), and rd_resp_valid, rd_grant, rd_status and op_err are all 0.
- R3: A read accepted in one cycle is answered in the next: rd_resp_valid is 1 exactly then. The answer is judged on the bank modes held before that edge. A granted read has rd_status equal to 0.
- R4: Reads are denied for a bank running a program (mode 1), an erase (mode 2), or a program inside a suspended erase (mode 5). A denied read gives rd_grant 0 and rd_status = {1, all-bank-erase flag, 2'b00, mode[3:0]}.
- R5: Reads are granted for a bank in program suspend (mode 3), erase suspend (mode 4), or program suspend inside an erase suspend (mode 6).
- R6: A read to a bank in read mode is granted while other banks are busy, unless R7 applies.
- R7: A multi-block erase (op code 3) takes a 9-bit bank mask. If the mask covers all nine banks, every read is denied with status bit 6 set while the members are erasing. The denial lasts until completion or suspend.
- R8: Operation codes are 1 program, 2 erase, 3 multi-erase, 4 suspend, 5 resume, 6 software reset and 7 hardware reset; code 0 does nothing. An illegal start is rejected with no change of state, and op_err is 1 in the next cycle. Illegal starts include a program or erase on a busy bank, and a multi-erase while another multi-erase exists or with a non-idle masked bank.
- R9: Suspend moves 1 to 3, 2 to 4 and 5 to 6; resume reverses each. A program on a bank in mode 4 gives mode 5. Suspend or resume of a multi-erase member acts on all members, and resume needs all of them in mode 4.
- R10: A normal completion returns modes 1 and 2 to 0 and mode 5 to 4. An abnormal completion puts the bank into lock, mode 7, where reads are denied. A completion on a multi-erase member ends the whole group.
- R11: A software reset returns a locked or idle bank to mode 0; on any other mode it is rejected per R8.
- R12: A hardware reset operation forces all banks to mode 0 and clears any multi-erase, without error, in the next cycle.
- R13: When a completion and an operation arrive in the same cycle, the completion is applied first, and the operation is judged on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| op_valid | input | 1 | Operation start strobe |
| op_code | input | 3 | Operation code (R8) |
| op_addr | input | 6 | Bank-address field of the operation |
| op_mask | input | 9 | Bank mask for multi-block erase |
| done_valid | input | 1 | Completion pulse from the timing model |
| done_addr | input | 6 | Bank-address field of the completion |
| done_fail | input | 1 | Completion was abnormal |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 6 | Bank-address field of the read |
| rd_resp_valid | output | 1 | Read answer present |
| rd_grant | output | 1 | Array data may be returned |
| rd_status | output | 8 | Busy/status code when denied |
| op_err | output | 1 | Previous cycle's operation was rejected |

## Verification
Every result of this block is registered once. A read or an operation presented before a clock edge has its rd_resp_valid, rd_grant, rd_status and op_err results visible after that edge. The read is judged on the bank modes as they were before the edge. The operation is judged after any completion arriving with it. The bench drives all inputs on the falling edge. It advances its reference model by one step per cycle and compares against the outputs at the next falling edge, so each answer is matched to the request that caused it.

// File: rtl/rww_pkg.sv
package rww_pkg;

    typedef enum logic [3:0] {
        BM_IDLE     = 4'd0,
        BM_PROG     = 4'd1,
        BM_ERASE    = 4'd2,
        BM_PSUSP    = 4'd3,
        BM_ESUSP    = 4'd4,
        BM_ES_PROG  = 4'd5,
        BM_ES_PSUSP = 4'd6,
        BM_LOCK     = 4'd7
    } bank_mode_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_MERASE = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5,
        OP_SWRST  = 3'd6,
        OP_HWRST  = 3'd7
    } op_code_e;

    localparam int MODE_W = 4;

endpackage

// File: rtl/rww_bank_decode.sv
module rww_bank_decode #(
    parameter int BA_W      = 6,
    parameter int SUB_BITS  = 3,
    parameter int NUM_BANKS = 9,
    parameter int IDX_W     = $clog2(NUM_BANKS)
) (
    input  logic [BA_W-1:0]  code,
    output logic [IDX_W-1:0] idx
);
    logic [BA_W-1:0] upper;

    always_comb begin
        upper = code >> SUB_BITS;
        if (code == '0) begin
            idx = '0;
        end else begin
            idx = IDX_W'(upper) + IDX_W'(1);
        end
    end

    always_comb begin
        if (!$isunknown(code)) begin
            AST_DECODE_RANGE: assert (idx < IDX_W'(NUM_BANKS)); // R1
        end
    end
endmodule

// File: rtl/rww_read_gate.sv
module rww_read_gate
    import rww_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              all_erase,
    output logic              grant,
    output logic [STAT_W-1:0] status
);
    logic readable;

    always_comb begin
        case (mode)
            BM_IDLE, BM_PSUSP, BM_ESUSP, BM_ES_PSUSP: readable = 1'b1;
            default:                                  readable = 1'b0;
        endcase
        grant  = readable && !all_erase;
        status = '0;
        if (!grant) begin
            status[STAT_W-1]     = 1'b1;
            status[STAT_W-2]     = all_erase;
            status[MODE_W-1:0]   = mode;
        end
    end
endmodule

// File: rtl/rww_bank_arbiter.sv
module rww_bank_arbiter
    import rww_pkg::*;
#(
    parameter int NUM_BANKS = 9,
    parameter int BA_W      = 6,
    parameter int SUB_BITS  = 3,
    parameter int STAT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [2:0]           op_code,
    input  logic [BA_W-1:0]      op_addr,
    input  logic [NUM_BANKS-1:0] op_mask,
    input  logic                 done_valid,
    input  logic [BA_W-1:0]      done_addr,
    input  logic                 done_fail,
    input  logic                 rd_valid,
    input  logic [BA_W-1:0]      rd_addr,
    output logic                 rd_resp_valid,
    output logic                 rd_grant,
    output logic [STAT_W-1:0]    rd_status,
    output logic                 op_err
);
    localparam int IDX_W = $clog2(NUM_BANKS);

    typedef struct packed {
        logic [NUM_BANKS-1:0][MODE_W-1:0] mode;
        logic [NUM_BANKS-1:0]             grp;
        logic                             rsp_v;
        logic                             grant;
        logic [STAT_W-1:0]                stat;
        logic                             err;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [IDX_W-1:0]  op_idx, dn_idx, rd_idx;
    logic              all_erase_q;
    logic              gate_grant;
    logic [STAT_W-1:0] gate_stat;

    rww_bank_decode #(.BA_W(BA_W), .SUB_BITS(SUB_BITS), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W))
        u_dec_op (.code(op_addr), .idx(op_idx));
    rww_bank_decode #(.BA_W(BA_W), .SUB_BITS(SUB_BITS), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W))
        u_dec_done (.code(done_addr), .idx(dn_idx));
    rww_bank_decode #(.BA_W(BA_W), .SUB_BITS(SUB_BITS), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W))
        u_dec_rd (.code(rd_addr), .idx(rd_idx));

    // All nine banks erasing together in one multi-erase blocks every read.
    assign all_erase_q = (&st_q.grp) && (st_q.mode[0] == BM_ERASE);

    rww_read_gate #(.STAT_W(STAT_W)) u_gate (
        .mode      (st_q.mode[rd_idx]),
        .all_erase (all_erase_q),
        .grant     (gate_grant),
        .status    (gate_stat)
    );

    always_comb begin
        logic [MODE_W-1:0] cur;
        logic              ok;
        logic              fail_mode;

        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.rsp_v = rd_valid;
        st_d.grant = 1'b0;
        st_d.stat  = '0;
        cur        = '0;
        ok         = 1'b0;
        fail_mode  = 1'b0;

        if (rd_valid) begin
            st_d.grant = gate_grant;
            st_d.stat  = gate_stat;
        end

        if (op_valid && op_code == OP_HWRST) begin
            st_d.mode = '0;
            st_d.grp  = '0;
        end else begin
            // completion first
            if (done_valid) begin
                cur = st_d.mode[dn_idx];
                unique case (cur)
                    BM_PROG: st_d.mode[dn_idx] = done_fail ? BM_LOCK : BM_IDLE;
                    BM_ES_PROG: st_d.mode[dn_idx] = done_fail ? BM_LOCK : BM_ESUSP;
                    BM_ERASE: begin
                        if (st_d.grp[dn_idx]) begin
                            for (int i = 0; i < NUM_BANKS; i++) begin
                                if (st_d.grp[i]) st_d.mode[i] = done_fail ? BM_LOCK : BM_IDLE;
                            end
                            st_d.grp = '0;
                        end else begin
                            st_d.mode[dn_idx] = done_fail ? BM_LOCK : BM_IDLE;
                        end
                    end
                    default: ;
                endcase
            end

            if (op_valid && op_code != OP_NONE) begin
                cur = st_d.mode[op_idx];
                ok  = 1'b0;
                case (op_code)
                    OP_PROG: begin
                        if (cur == BM_IDLE) begin
                            st_d.mode[op_idx] = BM_PROG;    ok = 1'b1;
                        end else if (cur == BM_ESUSP) begin
                            st_d.mode[op_idx] = BM_ES_PROG; ok = 1'b1;
                        end
                    end
                    OP_ERASE: begin
                        if (cur == BM_IDLE) begin
                            st_d.mode[op_idx] = BM_ERASE;   ok = 1'b1;
                        end
                    end
                    OP_MERASE: begin
                        ok = (op_mask != '0) && (st_d.grp == '0);
                        for (int i = 0; i < NUM_BANKS; i++) begin
                            if (op_mask[i] && st_d.mode[i] != BM_IDLE) ok = 1'b0;
                        end
                        if (ok) begin
                            for (int i = 0; i < NUM_BANKS; i++) begin
                                if (op_mask[i]) st_d.mode[i] = BM_ERASE;
                            end
                            st_d.grp = op_mask;
                        end
                    end
                    OP_SUSP: begin
                        if (cur == BM_PROG) begin
                            st_d.mode[op_idx] = BM_PSUSP;    ok = 1'b1;
                        end else if (cur == BM_ES_PROG) begin
                            st_d.mode[op_idx] = BM_ES_PSUSP; ok = 1'b1;
                        end else if (cur == BM_ERASE) begin
                            ok = 1'b1;
                            if (st_d.grp[op_idx]) begin
                                for (int i = 0; i < NUM_BANKS; i++) begin
                                    if (st_d.grp[i]) st_d.mode[i] = BM_ESUSP;
                                end
                            end else begin
                                st_d.mode[op_idx] = BM_ESUSP;
                            end
                        end
                    end
                    OP_RESUME: begin
                        if (cur == BM_PSUSP) begin
                            st_d.mode[op_idx] = BM_PROG;    ok = 1'b1;
                        end else if (cur == BM_ES_PSUSP) begin
                            st_d.mode[op_idx] = BM_ES_PROG; ok = 1'b1;
                        end else if (cur == BM_ESUSP) begin
                            if (st_d.grp[op_idx]) begin
                                ok = 1'b1;
                                for (int i = 0; i < NUM_BANKS; i++) begin
                                    if (st_d.grp[i] && st_d.mode[i] != BM_ESUSP) ok = 1'b0;
                                end
                                if (ok) begin
                                    for (int i = 0; i < NUM_BANKS; i++) begin
                                        if (st_d.grp[i]) st_d.mode[i] = BM_ERASE;
                                    end
                                end
                            end else begin
                                st_d.mode[op_idx] = BM_ERASE; ok = 1'b1;
                            end
                        end
                    end
                    OP_SWRST: begin
                        fail_mode = (cur == BM_LOCK);
                        if (fail_mode || cur == BM_IDLE) begin
                            st_d.mode[op_idx] = BM_IDLE; ok = 1'b1;
                        end
                    end
                    default: ok = 1'b1;
                endcase
                st_d.err = !ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_resp_valid = st_q.rsp_v;
    assign rd_grant      = st_q.grant;
    assign rd_status     = st_q.stat;
    assign op_err        = st_q.err;

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_resp_valid); // R3

    AST_DENY_CARRIES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_resp_valid && !rd_grant) |-> rd_status[STAT_W-1]); // R4

    AST_ALL_ERASE_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (all_erase_q && rd_valid) |=> (!rd_grant && rd_status[STAT_W-2])); // R7

    AST_ERR_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> $past(op_valid)); // R8

    AST_HWRST_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_HWRST) |=> (st_q.mode == '0 && st_q.grp == '0 && !op_err)); // R12

    AST_LOCK_ONLY_FROM_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode[0] == BM_LOCK && $past(st_q.mode[0]) != BM_LOCK) |-> $past(done_valid && done_fail)); // R10
endmodule

// File: tb/rww_bank_arbiter_bench.sv
`timescale 1ns/1ps
module rww_bank_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [5:0] op_addr = '0;
    logic [8:0] op_mask = '0;
    logic       done_valid = 1'b0;
    logic [5:0] done_addr = '0;
    logic       done_fail = 1'b0;
    logic       rd_valid = 1'b0;
    logic [5:0] rd_addr = '0;
    logic       rd_resp_valid, rd_grant, op_err;
    logic [7:0] rd_status;

    int n_checks = 0;
    int n_errs   = 0;
    int mm[9];
    logic [8:0] gm;

    always #2 clk = ~clk;

    rww_bank_arbiter u_rww_bank_arbiter (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_mask(op_mask), .done_valid(done_valid),
        .done_addr(done_addr), .done_fail(done_fail), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid), .rd_grant(rd_grant),
        .rd_status(rd_status), .op_err(op_err)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int bank_of(int c);
        return (c == 0) ? 0 : (c / 8) + 1;
    endfunction

    function automatic bit all_erasing();
        return (gm == 9'h1FF) && (mm[0] == 2);
    endfunction

    // reference model: one cycle of state change, returns rejection
    task automatic model_step(bit ov, int oc, int oa, logic [8:0] om,
                              bit dv, int da, bit df, output bit rej);
        int b;
        bit ok;
        rej = 1'b0;
        if (ov && oc == 7) begin
            foreach (mm[i]) mm[i] = 0;
            gm = '0;
            return;
        end
        if (dv) begin
            b = bank_of(da);
            if (mm[b] == 1) mm[b] = df ? 7 : 0;
            else if (mm[b] == 5) mm[b] = df ? 7 : 4;
            else if (mm[b] == 2) begin
                if (gm[b]) begin
                    foreach (mm[i]) if (gm[i]) mm[i] = df ? 7 : 0;
                    gm = '0;
                end else mm[b] = df ? 7 : 0;
            end
        end
        if (!ov || oc == 0) return;
        b  = bank_of(oa);
        ok = 1'b0;
        case (oc)
            1: if (mm[b] == 0) begin mm[b] = 1; ok = 1; end
               else if (mm[b] == 4) begin mm[b] = 5; ok = 1; end
            2: if (mm[b] == 0) begin mm[b] = 2; ok = 1; end
            3: begin
                ok = (om != 0) && (gm == 0);
                foreach (mm[i]) if (om[i] && mm[i] != 0) ok = 0;
                if (ok) begin
                    foreach (mm[i]) if (om[i]) mm[i] = 2;
                    gm = om;
                end
            end
            4: if (mm[b] == 1) begin mm[b] = 3; ok = 1; end
               else if (mm[b] == 5) begin mm[b] = 6; ok = 1; end
               else if (mm[b] == 2) begin
                   ok = 1;
                   if (gm[b]) begin foreach (mm[i]) if (gm[i]) mm[i] = 4; end
                   else mm[b] = 4;
               end
            5: if (mm[b] == 3) begin mm[b] = 1; ok = 1; end
               else if (mm[b] == 6) begin mm[b] = 5; ok = 1; end
               else if (mm[b] == 4) begin
                   if (gm[b]) begin
                       ok = 1;
                       foreach (mm[i]) if (gm[i] && mm[i] != 4) ok = 0;
                       if (ok) foreach (mm[i]) if (gm[i]) mm[i] = 2;
                   end else begin mm[b] = 2; ok = 1; end
               end
            6: if (mm[b] == 7 || mm[b] == 0) begin mm[b] = 0; ok = 1; end
            default: ok = 1;
        endcase
        rej = !ok;
    endtask

    // one cycle: drive at falling edge, compare at next falling edge
    task automatic cyc(bit ov, int oc, int oa, logic [8:0] om, bit dv, int da, bit df,
                       bit rv, int ra, string tag);
        int  b, m;
        bit  glob, busy_other, e_grant, e_rej;
        int  e_stat;
        string rt;
        op_valid = ov; op_code = 3'(oc); op_addr = 6'(oa); op_mask = om;
        done_valid = dv; done_addr = 6'(da); done_fail = df;
        rd_valid = rv; rd_addr = 6'(ra);
        b = bank_of(ra); m = mm[b]; glob = all_erasing();
        busy_other = 1'b0;
        foreach (mm[i]) if (i != b && mm[i] != 0) busy_other = 1'b1;
        e_grant = !glob && (m == 0 || m == 3 || m == 4 || m == 6);
        e_stat  = e_grant ? 0 : (128 | (glob ? 64 : 0) | m);
        if (tag != "") rt = tag;
        else if (glob) rt = "R7";
        else if (m == 7) rt = "R10";
        else if (m == 1 || m == 2 || m == 5) rt = "R4";
        else if (m != 0) rt = "R5";
        else if (busy_other) rt = "R6";
        else rt = "R3";
        model_step(ov, oc, oa, om, dv, da, df, e_rej);
        @(posedge clk);
        @(negedge clk);
        check("R3", "resp_valid", int'(rd_resp_valid), int'(rv));
        if (rv) begin
            check(rt, "grant", int'(rd_grant), int'(e_grant));
            check(rt, "status", int'(rd_status), e_stat);
        end
        check((tag != "") ? tag : "R8", "op_err", int'(op_err), int'(e_rej));
    endtask

    task automatic rd(int ra, string tag);
        cyc(0, 0, 0, '0, 0, 0, 0, 1, ra, tag);
    endtask

    task automatic op(int oc, int oa, string tag);
        cyc(1, oc, oa, '0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #800000;
        n_errs++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (mm[i]) mm[i] = 0;
        gm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "reset resp_valid", int'(rd_resp_valid), 0);
        check("R2", "reset grant", int'(rd_grant), 0);
        check("R2", "reset status", int'(rd_status), 0);
        check("R2", "reset op_err", int'(op_err), 0);
        rd(37, "R2");

        // R1 decode boundaries
        op(1, 7, "R1");
        rd(1, "R1"); rd(0, "R1"); rd(8, "R1");
        cyc(0, 0, 0, '0, 1, 3, 0, 1, 7, "R10");
        op(1, 63, "R1");
        rd(56, "R1"); rd(55, "R1");
        cyc(0, 0, 0, '0, 1, 60, 0, 0, 0, "R10");

        // nested suspend in bank 3
        op(2, 16, "R9");
        rd(23, "R4");
        op(4, 16, "R9");  rd(17, "R9");
        op(1, 20, "R9");  rd(20, "R9");
        op(4, 21, "R9");  rd(19, "R9");
        op(5, 18, "R9");  rd(18, "R9");
        op(2, 18, "R8");
        cyc(0, 0, 0, '0, 1, 22, 0, 1, 16, "R10");
        op(5, 16, "R9");  rd(16, "R4");
        cyc(0, 0, 0, '0, 1, 16, 1, 1, 16, "R10");
        rd(16, "R10");
        op(1, 16, "R8");
        op(6, 16, "R11"); rd(16, "R11");
        op(1, 30, "R11"); op(6, 30, "R11");

        // all-bank multi-erase
        cyc(1, 3, 0, 9'h1FF, 0, 0, 0, 1, 0, "R7");
        for (int c = 0; c < 64; c += 9) rd(c, "R7");
        cyc(1, 3, 0, 9'h003, 0, 0, 0, 0, 0, "R8");
        op(4, 0, "R9");   rd(50, "R9");
        op(1, 50, "R9");  op(5, 0, "R9");
        cyc(0, 0, 0, '0, 1, 50, 0, 0, 0, "R10");
        op(5, 9, "R9");   rd(9, "R7");
        // completion and program in the same cycle
        cyc(1, 1, 40, '0, 1, 40, 0, 1, 40, "R13");
        rd(40, "R13"); rd(12, "R13");
        cyc(1, 7, 0, '0, 0, 0, 0, 1, 40, "R12");
        rd(40, "R12");
        cyc(1, 3, 0, 9'h1FF, 0, 0, 0, 0, 0, "R12");
        op(7, 0, "R12"); rd(0, "R12");

        // constrained random
        for (int k = 0; k < 6000; k++) begin
            bit ov, dv, df, rv;
            int oc;
            logic [8:0] om;
            ov = ($urandom % 100) < 35;
            oc = 1 + ($urandom % 6);
            if (($urandom % 60) == 0) oc = 7;
            om = (($urandom % 5) == 0) ? 9'h1FF : 9'($urandom);
            dv = ($urandom % 100) < 25;
            df = ($urandom % 8) == 0;
            rv = ($urandom % 100) < 70;
            cyc(ov, oc, int'($urandom % 64), om, dv, int'($urandom % 64), df,
                rv, int'($urandom % 64), "");
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule